// File: doc/BRIEF.md
# Interrupt Trigger Configuration Register Bank

This block holds the trigger-mode setting of every interrupt ID that an interrupt distributor serves. Each ID owns a two-bit field in a 32-bit word. The upper bit chooses edge-triggered (1) or level-sensitive (0) handling. The lower bit is reserved. Software reaches the fields through a plain register port: a byte address, write data, a write enable, a combinational read-data return and the index of the requesting processor.

The access rules depend on the interrupt class:
- **Software-generated IDs (0-15)** are fixed at edge.
- **Private IDs (16-31)** are either programmable with one copy per processor, or fixed by a build-time constant.
- **Shared IDs (32 and up)** are freely programmable.

The bank exports the mode in force for every private and shared input. It also runs one pending latch per input. A latch in level mode follows the input. A latch in edge mode captures rising edges until a clear strobe arrives.

Top module: `irq_cfg_bank`

## Requirements
- R1: The field of interrupt n lies in the word at byte address 0x0C00 + (n >> 4) * 4, in bits [2F+1:2F] with F = n mod 16. Bit 2F+1 is 1 for edge-triggered and 0 for level-sensitive. Address bits [1:0] are not decoded.
- R2: Every even bit (2F) of every word reads as zero, and a one written there has no effect.
- R3: The word at 0x0C00 (IDs 0-15) always reads 0xAAAAAAAA, and writes to it have no effect.
- R4: The upper bits of shared IDs are writable. They read back as written, and `spi_edge[n-32]` equals the upper bit of ID n.
- R5: With PPI_PROG = 1, the word at 0x0C04 is banked per processor. `reg_cpu` selects the copy to read or write, and a write from one processor leaves the other copies unchanged. `ppi_edge[c*16+k]` is the mode of ID 16+k for processor c.
- R6: With PPI_PROG = 0, the word at 0x0C04 reads the upper bits from PPI_RO_MODES (bit k gives ID 16+k), and writes have no effect. `ppi_edge` shows PPI_RO_MODES for every processor.
- R7: An address below 0x0C00, or at or above 0x0C00 + 4*(NUM_IRQ/16), reads zero, and a write to it changes no configuration bit.
- R8: After a synchronous active-low reset, every programmable upper bit is 0 (level) and every pending output is 0.
- R9: In level mode, a pending output equals its input as sampled at the previous clock edge.
- R10: In edge mode, a rising input sets a sticky pending bit that stays set until a clear strobe for that input. A rising edge in the same cycle as a clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the accessed word |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_cpu | input | CPU_W | Index of the requesting processor |
| reg_rdata | output | 32 | Read data (combinational from the address) |
| spi_in | input | NUM_IRQ-32 | Shared interrupt inputs, bit i is ID 32+i |
| spi_clr | input | NUM_IRQ-32 | Per-input clear strobes for edge pending bits |
| spi_edge | output | NUM_IRQ-32 | Mode in force per shared input (1 = edge) |
| spi_pend | output | NUM_IRQ-32 | Pending state per shared input |
| ppi_in | input | NUM_CPU*16 | Private inputs, bit c*16+k is ID 16+k of processor c |
| ppi_clr | input | NUM_CPU*16 | Clear strobes for private pending bits |
| ppi_edge | output | NUM_CPU*16 | Mode in force per private input |
| ppi_pend | output | NUM_CPU*16 | Pending state per private input |

## Verification
The bench builds two copies, each with 64 interrupt IDs and two processors. This gives two shared words and puts the first unmapped word at 0x0C10. The first copy sets PPI_PROG = 1, which exercises the per-processor banked private word and its isolation between processors. The second copy sets PPI_PROG = 0 with PPI_RO_MODES = 16'h0C00, so read-only edge bits for IDs 26 and 27 can be told apart from ignored writes. Both copies receive the same random writes to the mapped, unmapped and below-base addresses. The bench then runs directed level, sticky-edge and set-versus-clear sequences on shared inputs.

// File: rtl/irq_cfg_pkg.sv
// Package: constants and helpers shared by the trigger configuration bank.
// Assumes 32-bit words holding 16 two-bit fields each.
package irq_cfg_pkg;
    localparam int unsigned CFG_BASE     = 32'h0000_0C00;
    localparam int unsigned IDS_PER_WORD = 16;
    localparam logic [31:0] SGI_WORD     = 32'hAAAA_AAAA;

    typedef enum logic [1:0] {
        WCLS_NONE,
        WCLS_SGI,
        WCLS_PPI,
        WCLS_SPI
    } wcls_e;

    // Place 16 mode bits on the odd bit positions of a word.
    function automatic logic [31:0] spread_modes(input logic [15:0] m);
        logic [31:0] r;
        r = '0;
        for (int f = 0; f < 16; f++) r[2*f+1] = m[f];
        return r;
    endfunction

    // Collect the odd bit positions of a word into 16 mode bits.
    function automatic logic [15:0] gather_modes(input logic [31:0] w);
        logic [15:0] r;
        for (int f = 0; f < 16; f++) r[f] = w[2*f+1];
        return r;
    endfunction
endpackage

// File: rtl/irq_cfg_decode.sv
// Address decoder: classifies a byte address into the configuration word class
// and gives the shared-word index. Assumes NUM_WORDS >= 3, address bits [1:0] ignored.
module irq_cfg_decode
    import irq_cfg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_WORDS = 4,
    localparam int SPI_WORDS = NUM_WORDS - 2,
    localparam int SPI_IDX_W = (SPI_WORDS > 1) ? $clog2(SPI_WORDS) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    output wcls_e                cls,
    output logic [SPI_IDX_W-1:0] spi_idx
);
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-3:0] word;
    logic              in_map;

    // Offset from the base and the word index inside the map.
    always_comb begin
        off    = addr - ADDR_W'(CFG_BASE);
        word   = off[ADDR_W-1:2];
        in_map = (addr >= ADDR_W'(CFG_BASE)) && (word < (ADDR_W-2)'(NUM_WORDS));
    end

    // Word class and shared-word index.
    always_comb begin
        spi_idx = SPI_IDX_W'(word - (ADDR_W-2)'(2));
        if (!in_map)                     cls = WCLS_NONE;
        else if (word == '0)             cls = WCLS_SGI;
        else if (word == (ADDR_W-2)'(1)) cls = WCLS_PPI;
        else                             cls = WCLS_SPI;
    end
endmodule

// File: rtl/irq_ppi_cfg.sv
// Private-interrupt mode store. With PROG set, one 16-bit mode copy per
// processor, written and read through cpu_sel; otherwise modes are the
// constant RO_MODES. An out-of-range cpu_sel reads zero and writes nothing.
module irq_ppi_cfg #(
    parameter int          NUM_CPU  = 2,
    parameter int          CPU_W    = 1,
    parameter bit          PROG     = 1'b1,
    parameter logic [15:0] RO_MODES = 16'h0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [15:0]             wr_modes,
    input  logic [CPU_W-1:0]        cpu_sel,
    output logic [15:0]             rd_modes,
    output logic [NUM_CPU*16-1:0]   all_modes
);
    logic cpu_ok;

    // Requesting processor exists.
    always_comb cpu_ok = ({1'b0, cpu_sel} < (CPU_W+1)'(NUM_CPU));

    generate
        if (PROG) begin : g_banked
            logic [15:0] bank_q [NUM_CPU];
            for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
                // Per-processor copy; reset to level-sensitive.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        bank_q[c] <= '0;
                    else if (wr_en && cpu_ok && (cpu_sel == CPU_W'(c)))
                        bank_q[c] <= wr_modes;
                end
                assign all_modes[c*16 +: 16] = bank_q[c];
            end
            // Read the copy of the requesting processor.
            always_comb begin
                rd_modes = '0;
                for (int c = 0; c < NUM_CPU; c++)
                    if (cpu_ok && (cpu_sel == CPU_W'(c))) rd_modes = bank_q[c];
            end
        end else begin : g_fixed
            // Fixed modes, writes dropped.
            always_comb rd_modes = cpu_ok ? RO_MODES : 16'h0000;
            assign all_modes = {NUM_CPU{RO_MODES}};
        end
    endgenerate
endmodule

// File: rtl/irq_spi_cfg.sv
// Shared-interrupt mode store: SPI_WORDS words of 16 mode bits, each written
// when its index matches. Assumes the caller qualifies wr_en with the decode.
module irq_spi_cfg #(
    parameter int SPI_WORDS = 2,
    parameter int IDX_W     = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [15:0]               wr_modes,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [15:0]               rd_modes,
    output logic [SPI_WORDS*16-1:0]   all_modes
);
    logic [15:0] cfg_q [SPI_WORDS];

    generate
        for (genvar w = 0; w < SPI_WORDS; w++) begin : g_word
            // One mode word; reset to level-sensitive.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[w] <= '0;
                else if (wr_en && (wr_idx == IDX_W'(w)))
                    cfg_q[w] <= wr_modes;
            end
            assign all_modes[w*16 +: 16] = cfg_q[w];
        end
    endgenerate

    // Select the addressed word for read.
    always_comb begin
        rd_modes = '0;
        for (int w = 0; w < SPI_WORDS; w++)
            if (rd_idx == IDX_W'(w)) rd_modes = cfg_q[w];
    end
endmodule

// File: rtl/irq_pend_latch.sv
// Pending latches for N inputs. Level mode: pending is the input registered.
// Edge mode: a rising edge sets a sticky bit; clear drops it, set wins.
module irq_pend_latch #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_in,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] in_d_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] rise;

    // Rising-edge detect against last cycle's input.
    always_comb rise = sig_in & ~in_d_q;

    // Input history and pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_d_q <= '0;
            pend_q <= '0;
        end else begin
            in_d_q <= sig_in;
            pend_q <= (edge_mode & (rise | (pend_q & ~clr))) | (~edge_mode & sig_in);
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/irq_cfg_bank.sv
// Top: trigger configuration bank for an interrupt distributor. Decodes the
// register port, applies the class access rules, muxes read data and drives
// per-input modes and pending latches. Assumes NUM_IRQ is a multiple of 16, >= 48.
module irq_cfg_bank
    import irq_cfg_pkg::*;
#(
    parameter int          NUM_IRQ      = 64,
    parameter int          NUM_CPU      = 2,
    parameter int          ADDR_W       = 16,
    parameter bit          PPI_PROG     = 1'b1,
    parameter logic [15:0] PPI_RO_MODES = 16'h0000,
    localparam int NUM_WORDS = NUM_IRQ / IDS_PER_WORD,
    localparam int NUM_SPI   = NUM_IRQ - 32,
    localparam int SPI_WORDS = NUM_WORDS - 2,
    localparam int SPI_IDX_W = (SPI_WORDS > 1) ? $clog2(SPI_WORDS) : 1,
    localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int NUM_PPI   = NUM_CPU * 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    input  logic [CPU_W-1:0]   reg_cpu,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SPI-1:0] spi_in,
    input  logic [NUM_SPI-1:0] spi_clr,
    output logic [NUM_SPI-1:0] spi_edge,
    output logic [NUM_SPI-1:0] spi_pend,
    input  logic [NUM_PPI-1:0] ppi_in,
    input  logic [NUM_PPI-1:0] ppi_clr,
    output logic [NUM_PPI-1:0] ppi_edge,
    output logic [NUM_PPI-1:0] ppi_pend
);
    wcls_e                cls;
    logic [SPI_IDX_W-1:0] spi_idx;
    logic [15:0]          wr_modes;
    logic [15:0]          ppi_rd;
    logic [15:0]          spi_rd;
    logic                 ppi_wr;
    logic                 spi_wr;

    irq_cfg_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
        .addr    (reg_addr),
        .cls     (cls),
        .spi_idx (spi_idx)
    );

    // Upper bits only; reserved bits of the write are dropped here.
    always_comb begin
        wr_modes = gather_modes(reg_wdata);
        ppi_wr   = reg_we && (cls == WCLS_PPI);
        spi_wr   = reg_we && (cls == WCLS_SPI);
    end

    irq_ppi_cfg #(
        .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .PROG(PPI_PROG), .RO_MODES(PPI_RO_MODES)
    ) u_ppi (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ppi_wr),
        .wr_modes  (wr_modes),
        .cpu_sel   (reg_cpu),
        .rd_modes  (ppi_rd),
        .all_modes (ppi_edge)
    );

    irq_spi_cfg #(.SPI_WORDS(SPI_WORDS), .IDX_W(SPI_IDX_W)) u_spi (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (spi_wr),
        .wr_idx    (spi_idx),
        .wr_modes  (wr_modes),
        .rd_idx    (spi_idx),
        .rd_modes  (spi_rd),
        .all_modes (spi_edge)
    );

    // Read mux by word class; unmapped addresses return zero.
    always_comb begin
        unique case (cls)
            WCLS_SGI: reg_rdata = SGI_WORD;
            WCLS_PPI: reg_rdata = spread_modes(ppi_rd);
            WCLS_SPI: reg_rdata = spread_modes(spi_rd);
            default:  reg_rdata = '0;
        endcase
    end

    irq_pend_latch #(.N(NUM_SPI)) u_spi_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_in    (spi_in),
        .edge_mode (spi_edge),
        .clr       (spi_clr),
        .pend      (spi_pend)
    );

    irq_pend_latch #(.N(NUM_PPI)) u_ppi_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_in    (ppi_in),
        .edge_mode (ppi_edge),
        .clr       (ppi_clr),
        .pend      (ppi_pend)
    );
endmodule

// File: rtl/irq_cfg_bank_chk.sv
// Checker: temporal properties of the configuration bank, bound to every
// instance of irq_cfg_bank. Observes ports only.
module irq_cfg_bank_chk #(
    parameter int ADDR_W    = 16,
    parameter int NUM_WORDS = 4,
    parameter int NUM_SPI   = 32,
    parameter int NUM_PPI   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_we,
    input logic [31:0]        reg_rdata,
    input logic [NUM_SPI-1:0] spi_in,
    input logic [NUM_SPI-1:0] spi_clr,
    input logic [NUM_SPI-1:0] spi_edge,
    input logic [NUM_SPI-1:0] spi_pend,
    input logic [NUM_PPI-1:0] ppi_edge
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(32'h0C00);
    logic [ADDR_W-1:0] off;
    logic              oob;
    logic              sgi_hit;

    // Independent range test of the address.
    always_comb begin
        off     = reg_addr - BASE;
        oob     = (reg_addr < BASE) || (off[ADDR_W-1:2] >= (ADDR_W-2)'(NUM_WORDS));
        sgi_hit = (reg_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
    end

    a_r3_sgi_word: assert property (@(posedge clk) disable iff (!rst_n)
        sgi_hit |-> reg_rdata == 32'hAAAA_AAAA);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 32'h5555_5555) == 32'h0);

    a_r7_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        oob |-> reg_rdata == 32'h0);

    a_r7_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && oob) |=> ($stable(spi_edge) && $stable(ppi_edge)));

    generate
        for (genvar i = 0; i < NUM_SPI; i++) begin : g_spi
            a_r9_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
                !spi_edge[i] |=> spi_pend[i] == $past(spi_in[i]));

            a_r10_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (spi_edge[i] && spi_pend[i] && !spi_clr[i]) |=> spi_pend[i]);
        end
    endgenerate
endmodule

bind irq_cfg_bank irq_cfg_bank_chk #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .NUM_SPI(NUM_SPI), .NUM_PPI(NUM_PPI)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .spi_in    (spi_in),
    .spi_clr   (spi_clr),
    .spi_edge  (spi_edge),
    .spi_pend  (spi_pend),
    .ppi_edge  (ppi_edge)
);

// File: tb/tb_irq_cfg_bank.sv
// Bench: random register traffic against a bench model, plus directed
// pending-latch sequences. Two copies: banked private word and fixed one.
module tb_irq_cfg_bank;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] RO         = 16'h0C00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = 16'h0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [0:0]  reg_cpu = 1'b0;
    logic [31:0] spi_in = '0, spi_clr = '0, ppi_in = '0, ppi_clr = '0;
    logic [31:0] rdata, rdata_ro;
    logic [31:0] spi_edge, spi_pend, ppi_edge, ppi_pend;
    logic [31:0] spi_edge_ro, spi_pend_ro, ppi_edge_ro, ppi_pend_ro;

    int n_cmp = 0;
    int n_err = 0;
    logic [31:0] m_spi;
    logic [15:0] m_ppi [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cfg_bank #(.NUM_IRQ(64), .NUM_CPU(2), .ADDR_W(16), .PPI_PROG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_cpu(reg_cpu), .reg_rdata(rdata),
        .spi_in(spi_in), .spi_clr(spi_clr), .spi_edge(spi_edge), .spi_pend(spi_pend),
        .ppi_in(ppi_in), .ppi_clr(ppi_clr), .ppi_edge(ppi_edge), .ppi_pend(ppi_pend));

    irq_cfg_bank #(.NUM_IRQ(64), .NUM_CPU(2), .ADDR_W(16), .PPI_PROG(1'b0),
                   .PPI_RO_MODES(RO)) dut_ro (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_cpu(reg_cpu), .reg_rdata(rdata_ro),
        .spi_in(spi_in), .spi_clr(spi_clr), .spi_edge(spi_edge_ro), .spi_pend(spi_pend_ro),
        .ppi_in(ppi_in), .ppi_clr(ppi_clr), .ppi_edge(ppi_edge_ro), .ppi_pend(ppi_pend_ro));

    // Compare one value and log a failure.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Mode bits to word image (mode k on bit 2k+1).
    function automatic logic [31:0] img(input logic [15:0] m);
        logic [31:0] r = '0;
        for (int k = 0; k < 16; k++) if (m[k]) r |= 32'h1 << (2*k+1);
        return r;
    endfunction

    function automatic logic [15:0] modes_of(input logic [31:0] w);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[k] = w[2*k+1];
        return r;
    endfunction

    // Expected read word for either copy.
    function automatic logic [31:0] exp_rd(input logic [15:0] a, input int cpu, input bit ro);
        int w;
        if (a < 16'h0C00 || a >= 16'h0C10) return 32'h0;
        w = (int'(a) - 'h0C00) / 4;
        case (w)
            0:       return 32'hAAAA_AAAA;
            1:       return ro ? img(RO) : img(m_ppi[cpu]);
            2:       return img(m_spi[15:0]);
            default: return img(m_spi[31:16]);
        endcase
    endfunction

    // Register write of one cycle, then update the model.
    task automatic wr(input logic [15:0] a, input logic [31:0] d, input int cpu);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_cpu = 1'(cpu); reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (a >= 16'h0C04 && a < 16'h0C08) m_ppi[cpu] = modes_of(d);
        else if (a >= 16'h0C08 && a < 16'h0C0C) m_spi[15:0] = modes_of(d);
        else if (a >= 16'h0C0C && a < 16'h0C10) m_spi[31:16] = modes_of(d);
    endtask

    // Read both copies and compare with the model.
    task automatic rd(input logic [15:0] a, input int cpu, input string req);
        @(negedge clk);
        reg_addr = a; reg_cpu = 1'(cpu);
        #1;
        chk(req, rdata, exp_rd(a, cpu, 1'b0));
        chk({req, " fixed-copy"}, rdata_ro, exp_rd(a, cpu, 1'b1));
    endtask

    function automatic logic [15:0] pick_addr(input int k);
        case (k)
            0: return 16'h0C00;
            1: return 16'h0C04;
            2: return 16'h0C08;
            3: return 16'h0C0E;   // low bits not decoded
            4: return 16'h0C10;   // first unmapped word
            5: return 16'h0BFC;   // below base
            default: return 16'h1C08;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_spi = '0; m_ppi[0] = '0; m_ppi[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 spi_edge", spi_edge, 32'h0);
        chk("R8 spi_pend", spi_pend, 32'h0);
        chk("R8 ppi_edge", ppi_edge, 32'h0);
        chk("R6 fixed ppi_edge", ppi_edge_ro, {RO, RO});
        rd(16'h0C08, 0, "R8 spi word");
        rd(16'h0C04, 1, "R8 ppi word");
        // R3 write to SGI word ignored
        wr(16'h0C00, 32'h0, 0);
        rd(16'h0C00, 0, "R3 sgi word");
        // R2 reserved bits dropped, R1 position of ID 50 (word 3, bits 5:4)
        wr(16'h0C0C, 32'h5555_5575, 0);
        chk("R1 id50 edge", spi_edge, 32'h0004_0000);
        rd(16'h0C0C, 0, "R2 reserved zero");
        // R5 banked isolation
        wr(16'h0C04, 32'h0000_0002, 1);
        rd(16'h0C04, 0, "R5 cpu0 untouched");
        rd(16'h0C04, 1, "R5 cpu1 copy");
        chk("R6 fixed ppi_edge after write", ppi_edge_ro, {RO, RO});
        // R7 unmapped write has no effect
        wr(16'h0C10, 32'hFFFF_FFFF, 0);
        chk("R7 spi_edge", spi_edge, m_spi);
        rd(16'h0C10, 0, "R7 oob read");
        // Random traffic, R4 R5 R6 R7
        for (int it = 0; it < 300; it++) begin
            logic [15:0] a;
            int cpu;
            a = pick_addr($urandom_range(0, 6));
            cpu = $urandom_range(0, 1);
            wr(a, $urandom, cpu);
            chk("R4 spi_edge", spi_edge, m_spi);
            chk("R5 ppi_edge", ppi_edge, {m_ppi[1], m_ppi[0]});
            chk("R6 ppi_edge fixed", ppi_edge_ro, {RO, RO});
            rd(pick_addr($urandom_range(0, 6)), $urandom_range(0, 1), "R4 R5 R6 R7 random read");
        end
        // Directed pending: ID 32 edge, ID 33 level
        wr(16'h0C08, 32'h0000_0002, 0);
        wr(16'h0C0C, 32'h0, 0);
        chk("R4 directed modes", spi_edge, 32'h1);
        spi_in[1] = 1'b1;
        @(negedge clk);
        chk("R9 level high", 32'(spi_pend[1]), 32'h1);
        spi_in[1] = 1'b0;
        @(negedge clk);
        chk("R9 level low", 32'(spi_pend[1]), 32'h0);
        spi_in[0] = 1'b1;
        @(negedge clk);
        spi_in[0] = 1'b0;
        chk("R10 edge set", 32'(spi_pend[0]), 32'h1);
        @(negedge clk);
        @(negedge clk);
        chk("R10 sticky", 32'(spi_pend[0]), 32'h1);
        spi_clr[0] = 1'b1;
        @(negedge clk);
        spi_clr[0] = 1'b0;
        chk("R10 cleared", 32'(spi_pend[0]), 32'h0);
        spi_in[0] = 1'b1; spi_clr[0] = 1'b1;
        @(negedge clk);
        spi_clr[0] = 1'b0; spi_in[0] = 1'b0;
        chk("R10 set wins over clear", 32'(spi_pend[0]), 32'h1);
        spi_clr[0] = 1'b1;
        @(negedge clk);
        spi_clr[0] = 1'b0;
        chk("R10 clear again", 32'(spi_pend[0]), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule